// File: doc/BRIEF.md
# PCI 64-Bit Upper Lane Controller

This block runs the upper half of a 64-bit PCI interface: the upper 32 address/data lines, the upper four command/byte-enable lines and the 64-bit acknowledge. The device may act as initiator or as target. While bus reset is held, the block samples the 64-bit request line. The last level seen before reset releases decides whether the wide extension is in use until the next reset. When the extension is off, the block drives the upper lanes to a fixed constant so they never float.

When the extension is on, the core reports bus phases one cycle ahead: initiator address phase (plain or dual-address), initiator data phase, target read data phase, and the target claim that the core also registers onto device select. The block registers drive values and output enables for the next bus cycle. Every active-low bus signal is presented as a value and an enable, and the external pull-ups take over whenever an enable is low.

Two state machines do the work. The acknowledge machine has the states ACK_IDLE (released), ACK_ON (driven low) and ACK_PARK (driven high for one cycle). Its transitions are: IDLE to ON on claim with request, ON holds on claim with request, ON to PARK when either drops, PARK back to ON on claim with request, and PARK to IDLE otherwise. The lane machine has the states LN_IDLE, LN_MADDR (initiator address), LN_MWR (initiator write data), LN_MRD (initiator read data, byte enables only), LN_TRD (target read data), LN_TURN (forced gap) and LN_FIXED (extension off). From any state it moves to the candidate picked by priority: FIXED if the extension is off, then MADDR, then MWR/MRD, then TRD, then IDLE. When a move would pass the data lanes straight between initiator and target, it goes to TURN instead.

Top module: `wide_lane_ctrl`

## Requirements
- R1: While `rst_n` is low, `ad_hi_oe_o`, `cbe_hi_oe_o` and `ack64_oe_o` are all 0.
- R2: `wide_en_o` equals the inverse of `req64_n_i` as sampled at the last clock edge with `rst_n` low. It holds that value until `rst_n` goes low again.
- R3: With the extension off, from the first edge after reset release both lane groups are enabled, `ad_hi_o` equals FIXED_AD, `cbe_hi_o` equals FIXED_BE, and the acknowledge is never enabled.
- R4: With the extension on, the acknowledge is driven low (`ack64_oe_o`=1, `ack64_val_o`=0) in the cycle after an edge where `tgt_claim_i`=1 and `req64_n_i`=0. This is the same edge at which the core's device select takes effect.
- R5: The acknowledge stays low only while claim and request were both active at the previous edge. It is never low otherwise.
- R6: When the acknowledge leaves the low state, it is driven high for exactly one cycle and then released (enable 0). The exception is a new claim with request during that cycle, which returns it to low.
- R7: An initiator address phase enables both lane groups. With `mst_dac_i`=1 and `mst_wide_i`=1, `ad_hi_o`=`addr_hi_i` and `cbe_hi_o`=`cmd_hi_i`. Otherwise the lanes carry FIXED_AD / FIXED_BE.
- R8: An initiator data phase with `mst_wide_i`=1 and `ack64_n_i`=0 sampled drives `cbe_hi_o` = bitwise inverse of the active-high `be_hi_i` (bit k low means byte k enabled). For a write (`mst_write_i`=1) it also drives `ad_hi_o`=`data_hi_i`. Without both conditions, the lanes stay off.
- R9: A target read data phase drives `ad_hi_o`=`data_hi_i`, with `cbe_hi_oe_o`=0, only in a cycle where the acknowledge is driven low.
- R10: Drive of the data lanes never passes directly between initiator (address or write data) and target (read data). A request for such a switch gives one cycle with both lane enables 0.
- R11: With no phase requested, both lane enables are 0 (no parking).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low |
| req64_n_i | input | 1 | Sampled 64-bit request line, active low |
| ack64_n_i | input | 1 | Sampled 64-bit acknowledge from the remote target, active low |
| tgt_claim_i | input | 1 | Core asserts device select for the next cycle |
| mst_addr_i | input | 1 | Initiator address phase next cycle |
| mst_dac_i | input | 1 | That address phase is dual-address |
| mst_wide_i | input | 1 | Current initiator transaction requests 64 bits |
| mst_data_i | input | 1 | Initiator data phase next cycle |
| mst_write_i | input | 1 | Initiator transfer is a write |
| tgt_rd_i | input | 1 | Target read data phase next cycle |
| addr_hi_i | input | AD_W | Upper address bits |
| cmd_hi_i | input | BE_W | Bus command for the upper lanes |
| data_hi_i | input | AD_W | Upper data from the core |
| be_hi_i | input | BE_W | Upper byte enables, active high |
| wide_en_o | output | 1 | Extension enabled status |
| ack64_val_o | output | 1 | Acknowledge drive value |
| ack64_oe_o | output | 1 | Acknowledge output enable |
| ad_hi_o | output | AD_W | Upper address/data drive value |
| ad_hi_oe_o | output | 1 | Upper address/data output enable |
| cbe_hi_o | output | BE_W | Upper command/byte-enable drive value |
| cbe_hi_oe_o | output | 1 | Upper command/byte-enable output enable |

## Verification
The bench builds the block with 32-bit data lanes and 4-bit byte lanes. It overrides the fixed levels to FIXED_AD = 32'hA5C3_0F96 and FIXED_BE = 4'h6, a pattern that can be told apart from zero, from all-ones pull-up levels and from random data. That makes the disabled mode and the non-dual-address phases checkable by value. Two reset passes, one with the request low and one with it high, bring both extension modes within reach. The random claim and request patterns exercise every acknowledge transition, including the return from the one-cycle high straight back to low.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_ON   = 2'd1,
        ACK_PARK = 2'd2
    } ack_state_t;

    typedef enum logic [2:0] {
        LN_IDLE  = 3'd0,
        LN_MADDR = 3'd1,
        LN_MWR   = 3'd2,
        LN_MRD   = 3'd3,
        LN_TRD   = 3'd4,
        LN_TURN  = 3'd5,
        LN_FIXED = 3'd6
    } lane_state_t;

    // Initiator is the owner of the upper data lanes in this state.
    function automatic logic init_owns_ad(lane_state_t s);
        return (s == LN_MADDR) || (s == LN_MWR);
    endfunction

endpackage

// File: rtl/wl_mode_latch.sv
module wl_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req64_n_i,
    output logic wide_en_o
);
    logic en_q;

    // Track request level through reset; freeze once reset releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= !req64_n_i;
        end
    end

    assign wide_en_o = en_q;

    a_r2_hold_after_reset: assert property (
        @(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(wide_en_o)
    );

endmodule

// File: rtl/wl_ack_fsm.sv
module wl_ack_fsm
    import wl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_en_i,
    input  logic claim_i,
    input  logic req64_n_i,
    output logic ack_go_o,
    output logic ack_val_o,
    output logic ack_oe_o
);
    ack_state_t state_q, state_d;
    logic       want;

    assign want = ext_en_i && claim_i && !req64_n_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: state_d = want ? ACK_ON : ACK_IDLE;
            ACK_ON:   state_d = want ? ACK_ON : ACK_PARK;
            ACK_PARK: state_d = want ? ACK_ON : ACK_IDLE;
            default:  state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ack_oe_o  = 1'b0;
        ack_val_o = 1'b1;
        unique case (state_q)
            ACK_IDLE: begin ack_oe_o = 1'b0; ack_val_o = 1'b1; end
            ACK_ON:   begin ack_oe_o = 1'b1; ack_val_o = 1'b0; end
            ACK_PARK: begin ack_oe_o = 1'b1; ack_val_o = 1'b1; end
            default:  begin ack_oe_o = 1'b0; ack_val_o = 1'b1; end
        endcase
    end

    assign ack_go_o = (state_d == ACK_ON);

    a_r5_ack_needs_req: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ack_oe_o && !ack_val_o) |-> $past(claim_i && !req64_n_i && ext_en_i)
    );

    a_r6_high_one_cycle: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ack_oe_o && ack_val_o) |=> !(ack_oe_o && ack_val_o)
    );

    a_r6_release_after_high: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(ack_oe_o) |-> $past(ack_val_o)
    );

endmodule

// File: rtl/wl_lane_fsm.sv
module wl_lane_fsm
    import wl_pkg::*;
#(
    parameter int            AD_W     = 32,
    parameter int            BE_W     = 4,
    parameter logic [AD_W-1:0] FIXED_AD = '0,
    parameter logic [BE_W-1:0] FIXED_BE = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_en_i,
    input  logic            ack_go_i,
    input  logic            ack64_n_i,
    input  logic            mst_addr_i,
    input  logic            mst_dac_i,
    input  logic            mst_wide_i,
    input  logic            mst_data_i,
    input  logic            mst_write_i,
    input  logic            tgt_rd_i,
    input  logic [AD_W-1:0] addr_hi_i,
    input  logic [BE_W-1:0] cmd_hi_i,
    input  logic [AD_W-1:0] data_hi_i,
    input  logic [BE_W-1:0] be_hi_i,
    output logic [AD_W-1:0] ad_hi_o,
    output logic            ad_oe_o,
    output logic [BE_W-1:0] cbe_hi_o,
    output logic            cbe_oe_o
);
    lane_state_t     state_q, state_d, cand;
    logic [AD_W-1:0] ad_q, ad_d;
    logic [BE_W-1:0] cbe_q, cbe_d;
    logic            clash;

    // Candidate phase by priority, with its lane values.
    always_comb begin
        cand  = LN_IDLE;
        ad_d  = ad_q;
        cbe_d = cbe_q;
        if (!ext_en_i) begin
            cand  = LN_FIXED;
            ad_d  = FIXED_AD;
            cbe_d = FIXED_BE;
        end else if (mst_addr_i) begin
            cand = LN_MADDR;
            if (mst_dac_i && mst_wide_i) begin
                ad_d  = addr_hi_i;
                cbe_d = cmd_hi_i;
            end else begin
                ad_d  = FIXED_AD;
                cbe_d = FIXED_BE;
            end
        end else if (mst_data_i && mst_wide_i && !ack64_n_i) begin
            cand  = mst_write_i ? LN_MWR : LN_MRD;
            ad_d  = data_hi_i;
            cbe_d = ~be_hi_i;
        end else if (tgt_rd_i && ack_go_i) begin
            cand = LN_TRD;
            ad_d = data_hi_i;
        end
    end

    assign clash = (init_owns_ad(state_q) && (cand == LN_TRD)) ||
                   ((state_q == LN_TRD) && init_owns_ad(cand));

    always_comb begin
        state_d = clash ? LN_TURN : cand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            ad_q    <= FIXED_AD;
            cbe_q   <= FIXED_BE;
        end else begin
            state_q <= state_d;
            ad_q    <= ad_d;
            cbe_q   <= cbe_d;
        end
    end

    always_comb begin
        ad_oe_o  = 1'b0;
        cbe_oe_o = 1'b0;
        unique case (state_q)
            LN_IDLE:  begin ad_oe_o = 1'b0; cbe_oe_o = 1'b0; end
            LN_MADDR: begin ad_oe_o = 1'b1; cbe_oe_o = 1'b1; end
            LN_MWR:   begin ad_oe_o = 1'b1; cbe_oe_o = 1'b1; end
            LN_MRD:   begin ad_oe_o = 1'b0; cbe_oe_o = 1'b1; end
            LN_TRD:   begin ad_oe_o = 1'b1; cbe_oe_o = 1'b0; end
            LN_TURN:  begin ad_oe_o = 1'b0; cbe_oe_o = 1'b0; end
            LN_FIXED: begin ad_oe_o = 1'b1; cbe_oe_o = 1'b1; end
            default:  begin ad_oe_o = 1'b0; cbe_oe_o = 1'b0; end
        endcase
    end

    assign ad_hi_o  = ad_q;
    assign cbe_hi_o = cbe_q;

    a_r10_no_init_to_tgt: assert property (
        @(posedge clk) disable iff (!rst_n)
        init_owns_ad(state_q) |=> (state_q != LN_TRD)
    );

    a_r10_no_tgt_to_init: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == LN_TRD) |=> !init_owns_ad(state_q)
    );

    a_r3_fixed_drive: assert property (
        @(posedge clk) disable iff (!rst_n)
        !ext_en_i |=> (ad_oe_o && cbe_oe_o && ad_hi_o == FIXED_AD && cbe_hi_o == FIXED_BE)
    );

    a_r8_narrow_data_off: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ext_en_i && !mst_addr_i && mst_data_i && !mst_wide_i && !tgt_rd_i) |=> !cbe_oe_o
    );

endmodule

// File: rtl/wide_lane_ctrl.sv
module wide_lane_ctrl
    import wl_pkg::*;
#(
    parameter int            AD_W     = 32,
    parameter int            BE_W     = 4,
    parameter logic [AD_W-1:0] FIXED_AD = '0,
    parameter logic [BE_W-1:0] FIXED_BE = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req64_n_i,
    input  logic            ack64_n_i,
    input  logic            tgt_claim_i,
    input  logic            mst_addr_i,
    input  logic            mst_dac_i,
    input  logic            mst_wide_i,
    input  logic            mst_data_i,
    input  logic            mst_write_i,
    input  logic            tgt_rd_i,
    input  logic [AD_W-1:0] addr_hi_i,
    input  logic [BE_W-1:0] cmd_hi_i,
    input  logic [AD_W-1:0] data_hi_i,
    input  logic [BE_W-1:0] be_hi_i,
    output logic            wide_en_o,
    output logic            ack64_val_o,
    output logic            ack64_oe_o,
    output logic [AD_W-1:0] ad_hi_o,
    output logic            ad_hi_oe_o,
    output logic [BE_W-1:0] cbe_hi_o,
    output logic            cbe_hi_oe_o
);
    logic ext_en;
    logic ack_go;
    logic ack_oe_raw;
    logic ad_oe_raw;
    logic cbe_oe_raw;

    wl_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req64_n_i (req64_n_i),
        .wide_en_o (ext_en)
    );

    wl_ack_fsm u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en_i  (ext_en),
        .claim_i   (tgt_claim_i),
        .req64_n_i (req64_n_i),
        .ack_go_o  (ack_go),
        .ack_val_o (ack64_val_o),
        .ack_oe_o  (ack_oe_raw)
    );

    wl_lane_fsm #(
        .AD_W     (AD_W),
        .BE_W     (BE_W),
        .FIXED_AD (FIXED_AD),
        .FIXED_BE (FIXED_BE)
    ) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_en_i    (ext_en),
        .ack_go_i    (ack_go),
        .ack64_n_i   (ack64_n_i),
        .mst_addr_i  (mst_addr_i),
        .mst_dac_i   (mst_dac_i),
        .mst_wide_i  (mst_wide_i),
        .mst_data_i  (mst_data_i),
        .mst_write_i (mst_write_i),
        .tgt_rd_i    (tgt_rd_i),
        .addr_hi_i   (addr_hi_i),
        .cmd_hi_i    (cmd_hi_i),
        .data_hi_i   (data_hi_i),
        .be_hi_i     (be_hi_i),
        .ad_hi_o     (ad_hi_o),
        .ad_oe_o     (ad_oe_raw),
        .cbe_hi_o    (cbe_hi_o),
        .cbe_oe_o    (cbe_oe_raw)
    );

    // Reset tristates every bus driver at once, without waiting for a clock (R1).
    assign wide_en_o   = ext_en;
    assign ack64_oe_o  = ack_oe_raw && rst_n;
    assign ad_hi_oe_o  = ad_oe_raw  && rst_n;
    assign cbe_hi_oe_o = cbe_oe_raw && rst_n;

    a_r9_tgt_data_with_ack: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ad_hi_oe_o && !cbe_hi_oe_o) |-> (ack64_oe_o && !ack64_val_o)
    );

    a_r3_no_ack_when_narrow: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wide_en_o |-> !ack64_oe_o
    );

endmodule

// File: tb/wide_lane_ctrl_tb.sv
module wide_lane_ctrl_tb;
    localparam int AD_W = 32;
    localparam int BE_W = 4;
    localparam logic [AD_W-1:0] FX_AD = 32'hA5C3_0F96;
    localparam logic [BE_W-1:0] FX_BE = 4'h6;

    logic clk = 1'b0;
    logic rst_n, req64_n, ack64_n, claim, m_addr, m_dac, m_wide, m_data, m_write, t_rd;
    logic [AD_W-1:0] addr_hi, data_hi;
    logic [BE_W-1:0] cmd_hi, be_hi;
    logic wide_en, ack_val, ack_oe, ad_oe, cbe_oe;
    logic [AD_W-1:0] ad_hi;
    logic [BE_W-1:0] cbe_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state: ack 0 idle/1 low/2 high; lane 0 idle,1 addr,2 wr,3 rd,4 tgt rd,5 gap,6 fixed
    int m_ack = 0;
    int m_ln = 0;
    bit m_ext = 0;
    logic [AD_W-1:0] m_ad = '0;
    logic [BE_W-1:0] m_cbe = '0;

    always #2 clk = ~clk;

    wide_lane_ctrl #(.AD_W(AD_W), .BE_W(BE_W), .FIXED_AD(FX_AD), .FIXED_BE(FX_BE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req64_n_i(req64_n), .ack64_n_i(ack64_n),
        .tgt_claim_i(claim), .mst_addr_i(m_addr), .mst_dac_i(m_dac), .mst_wide_i(m_wide),
        .mst_data_i(m_data), .mst_write_i(m_write), .tgt_rd_i(t_rd),
        .addr_hi_i(addr_hi), .cmd_hi_i(cmd_hi), .data_hi_i(data_hi), .be_hi_i(be_hi),
        .wide_en_o(wide_en), .ack64_val_o(ack_val), .ack64_oe_o(ack_oe),
        .ad_hi_o(ad_hi), .ad_hi_oe_o(ad_oe), .cbe_hi_o(cbe_hi), .cbe_hi_oe_o(cbe_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit init_ad(input int s);
        return (s == 1) || (s == 2);
    endfunction

    // Expected state after the coming edge, from the requirements.
    task automatic predict();
        int cand;
        bit go;
        if (!rst_n) begin
            m_ext = !req64_n;
            m_ack = 0;
            m_ln  = 0;
            return;
        end
        go = m_ext && claim && !req64_n;
        m_ack = go ? 1 : ((m_ack == 1) ? 2 : 0);
        cand = 0;
        if (!m_ext) begin
            cand = 6; m_ad = FX_AD; m_cbe = FX_BE;
        end else if (m_addr) begin
            cand = 1;
            if (m_dac && m_wide) begin m_ad = addr_hi; m_cbe = cmd_hi; end
            else begin m_ad = FX_AD; m_cbe = FX_BE; end
        end else if (m_data && m_wide && !ack64_n) begin
            cand = m_write ? 2 : 3; m_ad = data_hi; m_cbe = ~be_hi;
        end else if (t_rd && go) begin
            cand = 4; m_ad = data_hi;
        end
        if ((init_ad(m_ln) && cand == 4) || (m_ln == 4 && init_ad(cand))) cand = 5;
        m_ln = cand;
    endtask

    task automatic check_all();
        bit e_ack_oe, e_ad_oe, e_cbe_oe;
        string t_ack, t_lane;
        e_ack_oe = rst_n && (m_ack != 0);
        e_ad_oe  = rst_n && (m_ln == 1 || m_ln == 2 || m_ln == 4 || m_ln == 6);
        e_cbe_oe = rst_n && (m_ln == 1 || m_ln == 2 || m_ln == 3 || m_ln == 6);
        if (!rst_n) begin t_ack = "R1"; t_lane = "R1"; end
        else if (!m_ext) begin t_ack = "R3"; t_lane = "R3"; end
        else begin
            t_ack = (m_ack == 2) ? "R6" : "R4";
            t_lane = (m_ln == 0) ? "R11" : (m_ln == 5) ? "R10" : (m_ln == 4) ? "R9" : (m_ln == 1) ? "R7" : "R8";
        end
        chk(t_ack, ack_oe, e_ack_oe);
        if (e_ack_oe) chk((m_ack == 1) ? "R5" : "R6", ack_val, (m_ack == 2));
        chk(t_lane, ad_oe, e_ad_oe);
        chk(t_lane, cbe_oe, e_cbe_oe);
        if (e_ad_oe)  chk(t_lane, ad_hi, m_ad);
        if (e_cbe_oe) chk(t_lane, cbe_hi, m_cbe);
        if (rst_n) chk("R2", wide_en, m_ext);
    endtask

    task automatic cycle();
        predict();
        @(negedge clk);
        check_all();
    endtask

    task automatic quiet();
        claim = 0; m_addr = 0; m_dac = 0; m_wide = 0; m_data = 0; m_write = 0; t_rd = 0;
        ack64_n = 1;
    endtask

    task automatic rand_inputs();
        int kind;
        quiet();
        claim   = ($urandom % 4) != 0;
        req64_n = ($urandom % 4) == 0;
        ack64_n = ($urandom % 3) == 0;
        m_wide  = ($urandom % 4) != 0;
        addr_hi = $urandom; data_hi = $urandom;
        cmd_hi  = 4'($urandom); be_hi = 4'($urandom);
        kind = $urandom % 6;
        case (kind)
            1: begin m_addr = 1; m_dac = $urandom % 2; end
            2, 5: begin m_data = 1; m_write = $urandom % 2; end
            3, 4: t_rd = 1;
            default: ;
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; req64_n = 0;
        addr_hi = '0; data_hi = '0; cmd_hi = '0; be_hi = '0;
        quiet();
        // R1: enables off throughout reset, request low selects wide mode
        repeat (4) begin m_data = 1; m_wide = 1; ack64_n = 0; cycle(); end
        quiet();
        rst_n = 1;
        repeat (1500) begin rand_inputs(); cycle(); end

        // R4/R6 directed: three claimed cycles, then drop the claim
        quiet(); req64_n = 0; claim = 1;
        repeat (3) cycle();
        chk("R4", {ack_oe, ack_val}, 2'b10);
        claim = 0; cycle();
        chk("R6", {ack_oe, ack_val}, 2'b11);
        cycle();
        chk("R6", ack_oe, 1'b0);

        // R7 dual-address drive, then R10 gap before target read
        quiet(); repeat (2) cycle();
        chk("R11", {ad_oe, cbe_oe}, 2'b00);
        m_addr = 1; m_dac = 1; m_wide = 1; addr_hi = 32'h1234_5678; cmd_hi = 4'hD;
        cycle();
        chk("R7", ad_hi, 32'h1234_5678);
        chk("R7", cbe_hi, 4'hD);
        quiet(); t_rd = 1; claim = 1; req64_n = 0; data_hi = 32'hCAFE_0001;
        cycle();
        chk("R10", {ad_oe, cbe_oe}, 2'b00);
        chk("R10", {ack_oe, ack_val}, 2'b10);
        cycle();
        chk("R9", {ad_oe, cbe_oe}, 2'b10);
        chk("R9", ad_hi, 32'hCAFE_0001);

        // R3: reset with request high disables the extension
        quiet(); rst_n = 0; req64_n = 1;
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        chk("R3", ad_hi, FX_AD);
        chk("R2", wide_en, 1'b0);
        repeat (300) begin rand_inputs(); cycle(); end

        // back to wide mode
        quiet(); rst_n = 0; req64_n = 0;
        repeat (2) cycle();
        rst_n = 1;
        repeat (500) begin rand_inputs(); cycle(); end
        finish_run();
    end

endmodule